// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external host reach a small bank of registers over a four-signal serial link: an active-low select, a serial clock, a data input and a data output. Every transaction opens with one command byte. The command byte names a register and says whether the following transfer reads it or writes it. The selected register then moves across the link most significant bit first. Control registers are 8 bits wide. The data and calibration registers are 24 bits wide.

The serial clock, select and data inputs are oversampled in the system clock domain, so all state sits on `clk`. A polarity input picks which serial-clock level counts as idle. A link-recovery rule returns the slave to the command-awaiting state after a long run of ones on the data input. The select may be tied low (three-wire use); the host can then poll the external data-ready status through the top bit of the command register. The data register's word comes from outside the block. Each completed read of that word raises a one-cycle pulse, which the conversion side uses to clear its ready flag.

Top module: `sif_slave`

## Requirements
- R1: While `rst` is high, `sdo_oe` and `data_taken` are 0 and serial clock edges are ignored. After `rst` falls, the slave waits for a command byte.
- R2: Command byte layout, sent MSB first: bit 7 must be 0 for the byte to be accepted; bits 6:4 are the register address; bit 3 is 1 for read and 0 for write; bits 2:0 are spare. A byte with bit 7 set is discarded, and the slave keeps waiting for a command.
- R3: A write command to address 1, 2 or 3 takes the next 8 bits, and one to address 5, 6 or 7 takes the next 24 bits, MSB first. The value is stored in that register and is returned by later reads. Other registers are left unchanged.
- R4: A read command shifts the selected register out on `sdo`, MSB first. Each bit is driven at an inactive-going clock edge and stays valid through the next active-going edge, at which the slave advances.
- R5: Reading address 0 returns 8 bits: `rdy_n` in bit 7, and bits 6:0 of the last accepted command in bits 6:0. A write command to address 0 has no data phase.
- R6: Reading address 4 returns the 24-bit `data_word` input. The same word may be read again. A write to address 4 shifts in 24 bits and discards them.
- R7: `data_taken` pulses for one `clk` cycle after every completed read of address 4, and at no other time.
- R8: After 32 consecutive ones sampled on `sdi`, the slave returns to waiting for a command byte with no partial bits. Register contents are unchanged.
- R9: With `pol` = 1 the serial clock idles high, and data is sampled on its rising edge. With `pol` = 0 the clock idles low, and data is sampled on its falling edge.
- R10: While `cs_n` is high, `sdo_oe` is 0. A transfer cut short by `cs_n` going high restarts from its first bit at the next selection, and the pending command is kept.
- R11: While `standby` is high, `sdo_oe` is 0, serial activity is ignored and the interface returns to waiting for a command. Register contents are retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Power-down request; interface held idle |
| pol | input | 1 | Serial clock polarity: 1 idles high, 0 idles low |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| rdy_n | input | 1 | Active-low data-ready status from the conversion side |
| data_word | input | 24 | Current conversion result shown at address 4 |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| data_taken | output | 1 | One-cycle pulse after a full read of address 4 |

## Verification
The serial inputs pass through two synchronizer stages and an edge detector. Each slave response therefore lands about three `clk` cycles after the host's serial-clock change. A read's first bit is loaded two cycles after the command completes. `sdo_oe` follows the select one cycle after it leaves the synchronizer. The bench holds each serial-clock phase for eight `clk` cycles and samples `sdo` on a falling `clk` edge at the very end of the low phase, so every response has settled well before it is read. `data_taken` pulses are counted continuously and compared after each transaction has fully ended, which removes any dependence on the exact pulse cycle.

// File: rtl/sif_pkg.sv
package sif_pkg;

  typedef enum logic [1:0] {
    ST_CMD  = 2'd0,
    ST_PREP = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } sif_state_e;

  // Field width of a register, looked up from its address.
  function automatic int unsigned fld_width(input int unsigned addr,
                                            input int unsigned first_wide,
                                            input int unsigned narrow_w,
                                            input int unsigned wide_w);
    return (addr < first_wide) ? narrow_w : wide_w;
  endfunction

endpackage

// File: rtl/sif_edge.sv
module sif_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic standby,
  input  logic pol,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sel,
  output logic act_rise,
  output logic act_fall,
  output logic bit_o,
  output logic cs_drop
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sclk_p, cs_p, sdi_p;
  logic         s_lvl, s_q, sel_q, both;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      cs_p   <= '1;
      sdi_p  <= '0;
      s_q    <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[MSB-1:0], sclk};
      cs_p   <= {cs_p[MSB-1:0], cs_n};
      sdi_p  <= {sdi_p[MSB-1:0], sdi};
      s_q    <= s_lvl;
      sel_q  <= sel;
    end
  end

  // Active level: rising edge of s_lvl is the sampling edge.
  assign s_lvl    = pol ? sclk_p[MSB] : ~sclk_p[MSB];
  assign sel      = ~cs_p[MSB] & ~standby;
  assign both     = sel & sel_q;
  assign act_rise = both & s_lvl & ~s_q;
  assign act_fall = both & ~s_lvl & s_q;
  assign bit_o    = sdi_p[MSB];
  assign cs_drop  = sel_q & ~sel;

endmodule

// File: rtl/sif_recover.sv
module sif_recover #(
  parameter int ONES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic rise,
  input  logic bit_i,
  output logic recover
);
  localparam int RW = $clog2(ONES + 1);

  logic [RW-1:0] run;

  assign recover = rise & bit_i & (run == RW'(ONES - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      run <= '0;
    end else if (rise) begin
      run <= (bit_i && !recover) ? run + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/sif_regbank.sv
module sif_regbank #(
  parameter int ADDR_W = 3,
  parameter int WIDE_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sif_ctrl.sv
module sif_ctrl
  import sif_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int NARROW_W  = 8,
  parameter int WIDE_W    = 24,
  parameter int DATA_ADDR = 4,
  parameter int PREP_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              sel,
  input  logic              rise,
  input  logic              fall,
  input  logic              bit_i,
  input  logic              cs_drop,
  input  logic              recover,
  input  logic              rdy_n,
  input  logic [WIDE_W-1:0] data_word,
  input  logic [WIDE_W-1:0] mem_q,
  output logic [ADDR_W-1:0] raddr,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [WIDE_W-1:0] wdata,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              data_taken
);
  localparam int CMD_W  = 8;
  localparam int A_HI   = CMD_W - 2;
  localparam int RW_BIT = CMD_W - 2 - ADDR_W;
  localparam int CNT_W  = $clog2(WIDE_W + 1);
  localparam int PREP_W = $clog2(PREP_CYC + 1);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

  sif_state_e        st;
  logic [CNT_W-1:0]  bitcnt;
  logic [PREP_W-1:0] prep;
  logic [CMD_W-1:0]  cmd_sr, cmd_q, cmd_byte;
  logic [WIDE_W-1:0] isr, osr, raw, aligned, wmask;
  logic [ADDR_W-1:0] cur_addr, byte_addr;
  int unsigned       cur_w;
  logic [CNT_W-1:0]  last_bit;

  assign cmd_byte  = {cmd_sr[CMD_W-2:0], bit_i};
  assign byte_addr = cmd_byte[A_HI -: ADDR_W];
  assign cur_addr  = cmd_q[A_HI -: ADDR_W];
  assign cur_w     = fld_width(32'(cur_addr), DATA_ADDR, NARROW_W, WIDE_W);
  assign last_bit  = CNT_W'(cur_w - 1);
  assign wmask     = {WIDE_W{1'b1}} >> (WIDE_W - cur_w);
  assign raddr     = cur_addr;
  assign waddr     = cur_addr;
  assign wdata     = isr & wmask;

  always_comb begin
    if (cur_addr == '0)         raw = WIDE_W'({rdy_n, cmd_q[CMD_W-2:0]});
    else if (cur_addr == DATA_A) raw = data_word;
    else                         raw = mem_q;
    aligned = raw << (WIDE_W - cur_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_CMD;
      bitcnt     <= '0;
      prep       <= '0;
      cmd_sr     <= '0;
      cmd_q      <= '0;
      isr        <= '0;
      osr        <= '0;
      sdo        <= 1'b0;
      sdo_oe     <= 1'b0;
      data_taken <= 1'b0;
      we         <= 1'b0;
    end else begin
      sdo_oe     <= sel;
      data_taken <= 1'b0;
      we         <= 1'b0;
      if (standby || recover) begin
        st     <= ST_CMD;
        bitcnt <= '0;
      end else begin
        if (!sel) bitcnt <= '0;
        unique case (st)
          ST_CMD: if (rise) begin
            cmd_sr <= cmd_byte;
            if (bitcnt == CNT_W'(CMD_W - 1)) begin
              bitcnt <= '0;
              if (!cmd_byte[CMD_W-1]) begin
                cmd_q <= cmd_byte;
                if (cmd_byte[RW_BIT]) begin
                  st   <= ST_PREP;
                  prep <= '0;
                end else if (byte_addr != '0) begin
                  st <= ST_WR;
                end
              end
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_PREP: begin
            prep <= prep + 1'b1;
            if (prep == PREP_W'(PREP_CYC - 1)) begin
              osr <= aligned;
              st  <= ST_RD;
            end
          end
          ST_RD: begin
            if (cs_drop) begin
              st   <= ST_PREP;
              prep <= '0;
            end else if (fall) begin
              sdo <= osr[WIDE_W-1];
            end else if (rise) begin
              osr <= osr << 1;
              if (bitcnt == last_bit) begin
                st         <= ST_CMD;
                bitcnt     <= '0;
                data_taken <= (cur_addr == DATA_A);
              end else begin
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_WR: if (rise) begin
            isr <= {isr[WIDE_W-2:0], bit_i};
            if (bitcnt == last_bit) begin
              we     <= (cur_addr != DATA_A);
              st     <= ST_CMD;
              bitcnt <= '0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
            end
          end
          default: st <= ST_CMD;
        endcase
      end
    end
  end

  // R8
  recover_idle_chk: assert property (@(posedge clk) disable iff (rst)
    recover |=> (st == ST_CMD && bitcnt == '0));

  // R11
  standby_idle_chk: assert property (@(posedge clk) disable iff (rst)
    standby |=> (st == ST_CMD && bitcnt == '0 && !sdo_oe));

  // R10
  desel_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> ($stable(cmd_q) && !we));

  // R6
  we_addr_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> (waddr != '0 && waddr != DATA_A));

  // R7
  taken_chk: assert property (@(posedge clk) disable iff (rst)
    data_taken |-> ($past(st) == ST_RD && cur_addr == DATA_A));

endmodule

// File: rtl/sif_slave.sv
module sif_slave #(
  parameter int ADDR_W      = 3,
  parameter int NARROW_W    = 8,
  parameter int WIDE_W      = 24,
  parameter int DATA_ADDR   = 4,
  parameter int ONES        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              pol,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              rdy_n,
  input  logic [WIDE_W-1:0] data_word,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              data_taken
);
  logic              sel, act_rise, act_fall, bit_s, cs_drop, recover, we;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [WIDE_W-1:0] wdata, mem_q;

  sif_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .standby(standby), .pol(pol), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sel(sel), .act_rise(act_rise),
    .act_fall(act_fall), .bit_o(bit_s), .cs_drop(cs_drop)
  );

  sif_recover #(.ONES(ONES)) u_rec (
    .clk(clk), .rst(rst), .clr(standby), .rise(act_rise),
    .bit_i(bit_s), .recover(recover)
  );

  sif_regbank #(.ADDR_W(ADDR_W), .WIDE_W(WIDE_W)) u_bank (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(mem_q)
  );

  sif_ctrl #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W),
    .DATA_ADDR(DATA_ADDR), .PREP_CYC(2)
  ) u_ctrl (
    .clk(clk), .rst(rst), .standby(standby), .sel(sel), .rise(act_rise),
    .fall(act_fall), .bit_i(bit_s), .cs_drop(cs_drop), .recover(recover),
    .rdy_n(rdy_n), .data_word(data_word), .mem_q(mem_q), .raddr(raddr),
    .we(we), .waddr(waddr), .wdata(wdata), .sdo(sdo), .sdo_oe(sdo_oe),
    .data_taken(data_taken)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sdo_oe && !data_taken));

endmodule

// File: tb/sim_sif_slave.sv
module sim_sif_slave;
  localparam int H = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, standby = 1'b0, pol = 1'b1, cs_n = 1'b1;
  logic        sclk = 1'b1, sdi = 1'b0, rdy_n = 1'b1;
  logic [23:0] data_word = '0;
  logic        sdo, sdo_oe, data_taken;

  sif_slave u0 (
    .clk(clk), .rst(rst), .standby(standby), .pol(pol), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .rdy_n(rdy_n), .data_word(data_word),
    .sdo(sdo), .sdo_oe(sdo_oe), .data_taken(data_taken)
  );

  int vecs = 0, errs = 0, taken_n = 0;
  bit done = 1'b0;
  logic [23:0] shadow [8];

  always @(posedge clk) if (!rst && data_taken) taken_n <= taken_n + 1;

  function automatic int bw(input int a);
    return (a < 4) ? 8 : 24;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one serial bit: inactive-going edge, hold, sample sdo, active-going edge
  task automatic bitx(input logic b, output logic r);
    sclk = ~pol;
    sdi  = b;
    tick(H);
    r    = sdo;
    sclk = pol;
    tick(H);
  endtask

  task automatic xfer(input int n, input logic [23:0] v, output logic [23:0] r);
    logic b;
    r = '0;
    for (int i = n - 1; i >= 0; i--) begin
      bitx(v[i], b);
      r = {r[22:0], b};
    end
  endtask

  task automatic cmd(input int a, input logic rd);
    logic [23:0] d;
    xfer(8, {16'h0, 1'b0, 3'(a), rd, 3'b000}, d);
  endtask

  task automatic wr(input int a, input logic [23:0] v);
    logic [23:0] d;
    cmd(a, 1'b0);
    xfer(bw(a), v, d);
    tick(4);
  endtask

  task automatic rd(input int a, output logic [23:0] v);
    cmd(a, 1'b1);
    xfer(bw(a), 24'h0, v);
    tick(4);
  endtask

  task automatic set_pol(input logic p);
    cs_n = 1'b1;
    tick(4);
    pol  = p;
    sclk = p;
    tick(6);
    cs_n = 1'b0;
    tick(6);
  endtask

  function automatic logic [23:0] pat(input int a, input int k, input int p);
    logic [23:0] v;
    case (k)
      0:       v = 24'h000000;
      1:       v = 24'hFFFFFF;
      2:       v = 24'hA5C396 ^ 24'(a * 24'h010101);
      default: v = 24'((a + 1) * 24'h0F1E2D) ^ (p != 0 ? 24'hC3C3C3 : 24'h3C0F5A);
    endcase
    return (bw(a) == 8) ? {16'h0, v[7:0]} : v;
  endfunction

  initial begin
    logic [23:0] v, d;
    int t0;
    tick(3);
    cs_n = 1'b0;
    tick(4);
    // R1: quiet in reset, edges ignored
    chk("R1 sdo_oe in reset", {23'h0, sdo_oe}, 24'h0);
    chk("R1 data_taken in reset", {23'h0, data_taken}, 24'h0);
    for (int i = 0; i < 3; i++) bitx(1'b0, d[0]);
    rst = 1'b0;
    tick(6);
    chk("R1 sdo_oe after reset", {23'h0, sdo_oe}, 24'h1);

    // R3/R4/R9 sweep over both polarities
    for (int p = 1; p >= 0; p--) begin
      set_pol(p[0]);
      for (int k = 0; k < 4; k++) begin
        for (int a = 1; a < 8; a++) begin
          if (a == 4) continue;
          shadow[a] = pat(a, k, p);
          wr(a, shadow[a]);
        end
        for (int a = 1; a < 8; a++) begin
          if (a == 4) continue;
          rd(a, v);
          chk(p != 0 ? "R3 R4 R9 readback pol1" : "R3 R4 R9 readback pol0", v, shadow[a]);
        end
      end
    end
    set_pol(1'b1);

    // R5: command register read with status in bit 7
    rdy_n = 1'b1;
    rd(0, v);
    chk("R5 comms read rdy_n=1", v, 24'h000088);
    rdy_n = 1'b0;
    rd(0, v);
    chk("R5 comms read rdy_n=0", v, 24'h000008);
    cmd(0, 1'b0);
    rd(1, v);
    chk("R5 write to address 0 has no data phase", v, shadow[1]);

    // R2: byte with bit 7 set is discarded
    t0 = taken_n;
    xfer(8, 24'h0000C8, d);
    rd(2, v);
    chk("R2 invalid byte ignored", v, shadow[2]);
    chk("R2 no read started by invalid byte", 24'(taken_n - t0), 24'h0);

    // R6/R7: data register reads, repeat and write discard
    data_word = 24'h3C5A96;
    t0 = taken_n;
    rd(4, v);
    chk("R6 data read", v, 24'h3C5A96);
    rd(4, v);
    chk("R6 data re-read", v, 24'h3C5A96);
    chk("R7 two pulses", 24'(taken_n - t0), 24'h2);
    wr(4, 24'h123456);
    chk("R7 no pulse on write", 24'(taken_n - t0), 24'h2);
    rd(4, v);
    chk("R6 write to data discarded", v, 24'h3C5A96);
    chk("R7 third pulse", 24'(taken_n - t0), 24'h3);

    // R8: misaligned junk then 32 ones
    xfer(2, 24'h0, d);
    for (int i = 0; i < 32; i++) bitx(1'b1, d[0]);
    tick(4);
    rd(1, v);
    chk("R8 aligned after recovery", v, shadow[1]);
    rd(3, v);
    chk("R8 register unchanged", v, shadow[3]);

    // R10: aborted read restarts from MSB
    cmd(7, 1'b1);
    xfer(5, 24'h0, d);
    cs_n = 1'b1;
    tick(6);
    chk("R10 sdo_oe while deselected", {23'h0, sdo_oe}, 24'h0);
    cs_n = 1'b0;
    tick(6);
    xfer(24, 24'h0, v);
    tick(4);
    chk("R10 read restarted", v, shadow[7]);
    // R10: aborted write restarts
    cmd(1, 1'b0);
    xfer(3, 24'h5, d);
    cs_n = 1'b1;
    tick(6);
    cs_n = 1'b0;
    tick(6);
    xfer(8, 24'h00003C, d);
    tick(4);
    shadow[1] = 24'h00003C;
    rd(1, v);
    chk("R10 write restarted", v, shadow[1]);

    // R11: standby mid-write
    cmd(2, 1'b0);
    xfer(4, 24'hF, d);
    standby = 1'b1;
    tick(4);
    chk("R11 sdo_oe in standby", {23'h0, sdo_oe}, 24'h0);
    for (int i = 0; i < 6; i++) bitx(1'b1, d[0]);
    standby = 1'b0;
    tick(6);
    chk("R11 sdo_oe after standby", {23'h0, sdo_oe}, 24'h1);
    rd(2, v);
    chk("R11 register retained", v, shadow[2]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule